// File: doc/BRIEF.md
# SPI Transmit/Receive Queues with Watermark Interrupt

This block sits between the register interface of an SPI host controller and its serial shift engine. Software writes outgoing words into a transmit queue and drains incoming words from a receive queue. The shift engine takes words from the transmit queue and returns captured words to the receive queue, each through a valid/ready handshake. The serial shifting itself is done elsewhere.

Queue status has no separate register. It is reported in bit 31 of the two data registers. Two programmable thresholds set when each queue needs service. The interrupt-pending register shows these watermark conditions as live levels, computed every cycle from queue occupancy. An enable register masks them onto one interrupt line.

The register port uses single-cycle read and write strobes. Read data is combinational from the current state. A read of the receive data register pops the queue on the clock edge that ends the read.

Top module: `spi_wm_fifos`

## Requirements
- R1: After reset both queues are empty (`tx_valid` low, receive data reads bit 31 set), the enable register (0x70) reads 0, the transmit mark (0x50) reads 1 and the receive mark (0x54) reads 0.
- R2: A write to 0x48 pushes `reg_wdata[7:0]` into the transmit queue. The engine sees the words on `tx_data` in write order while `tx_valid` is high, and one word is removed on each cycle with `tx_valid` and `tx_ready` both high. A push and an engine pop may happen in the same cycle.
- R3: A read of 0x48 returns bit 31 set exactly when the transmit queue holds DEPTH words, with all other bits 0. A write to a full queue is dropped.
- R4: A read of 0x4C from a non-empty receive queue returns the oldest word in bits 7:0 with bit 31 clear, and removes that word. Words enter from the engine in `rx_valid`/`rx_ready` handshake order.
- R5: A read of 0x4C from an empty receive queue returns exactly 0x8000_0000 and changes no state.
- R6: Pending bit 0 (register 0x74) is 1 while the transmit occupancy is strictly less than the transmit mark.
- R7: Pending bit 1 (register 0x74) is 1 while the receive occupancy is strictly greater than the receive mark.
- R8: The enable register (0x70) uses the same bit layout as the pending register. `irq` is the OR of the pending bits masked by the enable bits.
- R9: `rx_ready` is low while the receive queue holds DEPTH words, and a word offered by the engine at that time is not accepted.
- R10: Writes to 0x4C and 0x74 have no effect, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Transmit queue holds a word for the engine |
| tx_data | output | DW | Oldest transmit word |
| tx_ready | input | 1 | Engine takes the transmit word |
| rx_valid | input | 1 | Engine offers a received word |
| rx_data | input | DW | Received word |
| rx_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Masked watermark interrupt |

## Verification
The embedded properties assume that reset is held high for at least one clock edge before any check counts. Beyond that they assume nothing about the strobes: `reg_wr` and `reg_rd` may coincide with engine handshakes on either queue. The overflow and no-pop properties therefore name the concurrent engine pop or push explicitly. The stimulus changes every input only on the falling clock edge and drives each strobe for exactly one cycle. It holds the engine side idle while the register table runs, so each expected value depends only on register traffic.

// File: rtl/spi_wm_fifos.sv
module spi_wm_fifos #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] OFS_TXD  = AW'('h48);
  localparam logic [AW-1:0] OFS_RXD  = AW'('h4C);
  localparam logic [AW-1:0] OFS_TXM  = AW'('h50);
  localparam logic [AW-1:0] OFS_RXM  = AW'('h54);
  localparam logic [AW-1:0] OFS_EN   = AW'('h70);
  localparam logic [AW-1:0] OFS_PEND = AW'('h74);

  logic [DW-1:0]    tx_mem [DEPTH];
  logic [DW-1:0]    rx_mem [DEPTH];
  logic [PTR_W-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_mark, rx_mark;
  logic [1:0]       en_q, pend;
  logic tx_full, rx_empty, tx_push, tx_pop, rx_push, rx_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tx_full  = (tx_cnt == CNT_W'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign tx_valid = (tx_cnt != '0);
  assign rx_ready = (rx_cnt != CNT_W'(DEPTH));
  assign tx_data  = tx_mem[tx_rp];

  assign tx_push = reg_wr && reg_addr == OFS_TXD && !tx_full;
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_push = rx_valid && rx_ready;
  assign rx_pop  = reg_rd && reg_addr == OFS_RXD && !rx_empty;

  assign pend = {rx_cnt > rx_mark, tx_cnt < tx_mark};
  assign irq  = |(pend & en_q);

  logic unused_wdata;
  assign unused_wdata = &{1'b0, reg_wdata};

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[DW-1:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_mark <= CNT_W'(1);
      rx_mark <= '0;
      en_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_TXM: tx_mark <= reg_wdata[CNT_W-1:0];
        OFS_RXM: rx_mark <= reg_wdata[CNT_W-1:0];
        OFS_EN:  en_q    <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_TXD:  reg_rdata[31] = tx_full;
      OFS_RXD: begin
        reg_rdata[31] = rx_empty;
        if (!rx_empty) reg_rdata[DW-1:0] = rx_mem[rx_rp];
      end
      OFS_TXM:  reg_rdata[CNT_W-1:0] = tx_mark;
      OFS_RXM:  reg_rdata[CNT_W-1:0] = rx_mark;
      OFS_EN:   reg_rdata[1:0] = en_q;
      OFS_PEND: reg_rdata[1:0] = pend;
      default: ;
    endcase
  end

  assert_tx_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= CNT_W'(DEPTH));
  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_full && reg_wr && reg_addr == OFS_TXD && !tx_ready) |=> tx_cnt == $past(tx_cnt));
  assert_empty_read_no_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && reg_rd && reg_addr == OFS_RXD && !rx_valid) |=> rx_empty);
  assert_rx_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && !reg_rd) |=> !rx_ready);
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (en_q != 2'b00));
  assert_txwm_on_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && tx_mark != '0) |-> pend[0]);
endmodule

// File: tb/spi_wm_fifos_tb_top.sv
module spi_wm_fifos_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
  logic [7:0] tx_data, rx_data = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wm_fifos #(.DEPTH(DEPTH), .DW(8), .AW(8)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .irq(irq));

  // op(1: write) | requirement | offset | write data | expected read
  localparam int NV = 17;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'd6,  8'h74, 32'h0,  32'h1},        // R6 empty TX below mark 1
    {1'b0, 8'd1,  8'h70, 32'h0,  32'h0},        // R1 enables
    {1'b0, 8'd1,  8'h50, 32'h0,  32'h1},        // R1 TX mark
    {1'b0, 8'd1,  8'h54, 32'h0,  32'h0},        // R1 RX mark
    {1'b0, 8'd5,  8'h4C, 32'h0,  32'h8000_0000}, // R5 empty RX
    {1'b0, 8'd3,  8'h48, 32'h0,  32'h0},        // R3 not full
    {1'b1, 8'd2,  8'h48, 32'hA1, 32'h0},        // R2 push
    {1'b0, 8'd6,  8'h74, 32'h0,  32'h0},        // R6 one word, mark 1
    {1'b1, 8'd6,  8'h50, 32'h3,  32'h0},
    {1'b0, 8'd6,  8'h74, 32'h0,  32'h1},        // R6 1 < 3
    {1'b1, 8'd8,  8'h70, 32'h3,  32'h0},
    {1'b0, 8'd8,  8'h70, 32'h0,  32'h3},        // R8 layout
    {1'b1, 8'd10, 8'h4C, 32'h55, 32'h0},
    {1'b0, 8'd10, 8'h4C, 32'h0,  32'h8000_0000}, // R10 RX write ignored
    {1'b0, 8'd10, 8'h10, 32'h0,  32'h0},        // R10 unmapped
    {1'b1, 8'd10, 8'h74, 32'h3,  32'h0},
    {1'b0, 8'd10, 8'h74, 32'h0,  32'h1}         // R10 pending write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1; reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
    @(posedge clk); @(negedge clk);
    reg_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_tx [8];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1 chk("R1 tx_valid after reset", 32'(tx_valid), 0);
    chk("R1 irq after reset", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) bus_wr(VEC[i][71:64], VEC[i][63:32]);
      else bus_rd(VEC[i][71:64], VEC[i][31:0], $sformatf("R%0d vector %0d", VEC[i][79:72], i));
    end

    #1 chk("R8 irq with txwm enabled", 32'(irq), 1);
    bus_wr(8'h70, 32'h2);
    #1 chk("R8 irq masked", 32'(irq), 0);

    exp_tx[0] = 8'hA1;
    for (int i = 1; i < 8; i++) begin
      exp_tx[i] = 8'hB0 + 8'(i);
      bus_wr(8'h48, 32'(exp_tx[i]));
    end
    bus_rd(8'h48, 32'h8000_0000, "R3 full flag");
    bus_wr(8'h48, 32'hEE);
    bus_rd(8'h74, 32'h0, "R6 full TX not below mark");
    tx_ready = 1;
    for (int i = 0; i < 8; i++) begin
      #1 chk("R2 tx_valid drain", 32'(tx_valid), 1);
      chk("R2 tx order", 32'(tx_data), 32'(exp_tx[i]));
      @(negedge clk);
    end
    #1 chk("R3 dropped word absent", 32'(tx_valid), 0);
    tx_ready = 0;

    bus_wr(8'h48, 32'hC1);
    reg_wr = 1; reg_addr = 8'h48; reg_wdata = 32'hC2; tx_ready = 1;
    #1 chk("R2 head before simultaneous push/pop", 32'(tx_data), 32'hC1);
    @(negedge clk);
    reg_wr = 0;
    #1 chk("R2 simultaneous push/pop keeps one", 32'(tx_valid), 1);
    chk("R2 second word", 32'(tx_data), 32'hC2);
    @(negedge clk);
    #1 chk("R2 queue drained", 32'(tx_valid), 0);
    tx_ready = 0;

    rx_valid = 1;
    for (int i = 0; i < 10; i++) begin
      rx_data = 8'h30 + 8'(i);
      #1 chk("R9 rx_ready", 32'(rx_ready), (i < 8) ? 1 : 0);
      @(negedge clk);
    end
    rx_valid = 0;
    bus_rd(8'h74, 32'h3, "R7 8 > mark 0");
    bus_wr(8'h54, 32'h7);
    bus_rd(8'h74, 32'h3, "R7 8 > mark 7");
    bus_wr(8'h54, 32'h8);
    bus_rd(8'h74, 32'h1, "R7 8 not > mark 8");
    #1 chk("R8 irq rx not pending", 32'(irq), 0);
    bus_wr(8'h54, 32'h7);
    #1 chk("R8 irq rx pending", 32'(irq), 1);
    for (int i = 0; i < 8; i++)
      bus_rd(8'h4C, 32'h30 + 32'(i), "R4 rx order");
    bus_rd(8'h4C, 32'h8000_0000, "R5 empty read");
    bus_rd(8'h4C, 32'h8000_0000, "R5 empty read repeated");
    #1 chk("R9 rx_ready after drain", 32'(rx_ready), 1);

    bus_wr(8'h48, 32'h77);
    bus_wr(8'h70, 32'h3);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    #1 chk("R1 tx_valid after mid reset", 32'(tx_valid), 0);
    chk("R1 irq after mid reset", 32'(irq), 0);
    bus_rd(8'h70, 32'h0, "R1 enable after reset");
    bus_rd(8'h50, 32'h1, "R1 tx mark after reset");
    bus_rd(8'h54, 32'h0, "R1 rx mark after reset");
    bus_rd(8'h4C, 32'h8000_0000, "R1 rx empty after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule